// File: doc/BRIEF.md
# SPI Serial Clock Prescaler and Frame Timing Generator

This block produces the serial clock and the chip-select framing for one character of an SPI master. A 32-bit mode word, held by the surrounding controller for the selected device, sets the prescale value and an extra divide by 16. It also sets the clock idle level, the sampling phase, the bit order, the character length, and the setup and hold gaps around the clock burst. A one-cycle start request begins a frame. The block raises a frame qualifier and drives the chip select to its active level. It waits out the setup gap, emits the character's SCK cycles, waits out the hold gap, and then pulses a done flag.

Alongside SCK the block gives the shifter two one-cycle strobes. One marks the edges where receive data is sampled and the other marks the edges where the next transmit bit is launched. It also passes on the latched bit order and character length, plus a flag for a bit order that the length does not support. The mode word is captured when a frame starts, so the controller may update it for the next device while a frame is still running.

Top module: `spi_sck_framer`

## Requirements
- R1: While reset is active and after reset is released, frame_active, sample_stb, shift_stb and frame_done are low, and sck and cs_level sit at the idle levels given by the live mode word.
- R2: One SCK half period lasts H = 2·(PM+1) system clocks, where PM is mode bits 27:24. When bit 28 is set, H = 32·(PM+1). The SCK period is therefore 4·(PM+1) or 64·(PM+1) clocks, so the slowest rate is clk/1024.
- R3: Whenever no frame is active, sck equals mode bit 31, so 1 means idle high. At the end of every frame, sck is back at that level.
- R4: A frame carries exactly L+1 SCK cycles, which is 2·(L+1) edges, where L is mode bits 19:16.
- R5: When mode bit 30 is 0, sample_stb pulses at every leading edge (the edge away from the idle level) and shift_stb pulses at every trailing edge except the last. When bit 30 is 1, shift_stb pulses at every leading edge and sample_stb at every trailing edge. Each strobe is high for one clock, in the cycle in which sck shows the new level.
- R6: The setup gap S (bits 15:12) and the hold gap A (bits 11:8) are counted in whole SCK periods. The first SCK edge comes (2S+1)·H clocks after the start is accepted. The frame ends 2A·H clocks after the last SCK edge.
- R7: The mode word is captured in the cycle a start is accepted. Changes to it during a frame have no effect on that frame, and a start request made during a frame is ignored.
- R8: Mode bit 20 set means the chip select is active low. cs_level shows the active level while frame_active is high and the inactive level otherwise.
- R9: frame_active stays high for exactly 2H·(S+L+1+A) clocks. frame_done is a single one-clock pulse in the first cycle after frame_active falls.
- R10: During a frame, msb_first shows the captured bit 29 and char_len_m1 shows the captured L. order_bad is high only when bit 29 is set and L is neither 7 nor 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_word | input | 32 | Per-device mode word |
| start | input | 1 | Frame start request, accepted only when idle |
| sck | output | 1 | Serial clock |
| cs_level | output | 1 | Chip-select pin level |
| frame_active | output | 1 | High for the whole frame, including gaps |
| sample_stb | output | 1 | Receive sampling strobe |
| shift_stb | output | 1 | Transmit launch strobe |
| frame_done | output | 1 | One-cycle end-of-frame pulse |
| msb_first | output | 1 | Captured bit order |
| char_len_m1 | output | 4 | Captured character length minus one |
| order_bad | output | 1 | Unsupported bit order for the captured length |

## Verification
On every cycle the assertions check several local properties. The prescaler count never passes its limit and wraps after each tick. Strobes appear only just after a prescaler tick. The clock toggle state is at rest outside the bit phase. The captured configuration never changes mid-frame, a done pulse follows only a frame's exit, and an idle start always opens a frame. What only the bench's sweeps can show is the arithmetic taken over whole frames: the half-period length for each prescale and divide setting, the total edge count, the gap lengths in clocks, and the edge-by-edge placement of the strobes for each polarity and phase. The sweeps also show that a mid-frame mode change or start leaves the running frame unchanged.

// File: rtl/spi_sck_pkg.sv
package spi_sck_pkg;

    localparam int MODE_W  = 32;
    localparam int FLD_W   = 4;
    localparam int CNT_W   = FLD_W + 2;

    // Field positions: a neighbouring register decodes these.
    localparam int POS_CPOL  = 31;
    localparam int POS_CPHA  = 30;
    localparam int POS_MSB   = 29;
    localparam int POS_DIV16 = 28;
    localparam int POS_PM    = 24;
    localparam int POS_CSLOW = 20;
    localparam int POS_LEN   = 16;
    localparam int POS_SETUP = 12;
    localparam int POS_HOLD  = 8;

    typedef struct packed {
        logic             cpol;
        logic             cpha;
        logic             msb;
        logic             div16;
        logic [FLD_W-1:0] pm;
        logic             cs_low;
        logic [FLD_W-1:0] len_m1;
        logic [FLD_W-1:0] setup;
        logic [FLD_W-1:0] hold;
    } mode_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SETUP = 2'd1,
        ST_BITS  = 2'd2,
        ST_HOLD  = 2'd3
    } seq_st_e;

    // Half periods spanned by a gap of f SCK periods.
    function automatic logic [CNT_W-1:0] gap_halves(logic [FLD_W-1:0] f);
        return {1'b0, f, 1'b0};
    endfunction

    // Half periods spanned by a character of len_m1+1 bits.
    function automatic logic [CNT_W-1:0] bit_halves(logic [FLD_W-1:0] len_m1);
        logic [FLD_W:0] nb;
        nb = {1'b0, len_m1} + 1'b1;
        return {nb, 1'b0};
    endfunction

endpackage

// File: rtl/spi_mode_decode.sv
module spi_mode_decode
    import spi_sck_pkg::*;
(
    input  logic [MODE_W-1:0] mode_word,
    output mode_t             cfg
);
    logic unused_bits;
    assign unused_bits = ^{mode_word[23:21], mode_word[7:0]};

    always_comb begin
        cfg.cpol   = mode_word[POS_CPOL];
        cfg.cpha   = mode_word[POS_CPHA];
        cfg.msb    = mode_word[POS_MSB];
        cfg.div16  = mode_word[POS_DIV16];
        cfg.pm     = mode_word[POS_PM    +: FLD_W];
        cfg.cs_low = mode_word[POS_CSLOW];
        cfg.len_m1 = mode_word[POS_LEN   +: FLD_W];
        cfg.setup  = mode_word[POS_SETUP +: FLD_W];
        cfg.hold   = mode_word[POS_HOLD  +: FLD_W];
    end
endmodule

// File: rtl/spi_sck_prescaler.sv
module spi_sck_prescaler #(
    parameter int PM_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    input  logic [PM_W-1:0] pm,
    input  logic            div16,
    output logic            tick
);
    localparam int FAST_SHIFT = 1;
    localparam int SLOW_SHIFT = FAST_SHIFT + 4;
    localparam int DIV_W      = PM_W + SLOW_SHIFT + 1;

    logic [DIV_W-1:0] cnt_d, cnt_q;
    logic [DIV_W-1:0] base, limit;

    always_comb begin
        base  = DIV_W'(pm) + DIV_W'(1);
        limit = div16 ? (base << SLOW_SHIFT) - DIV_W'(1)
                      : (base << FAST_SHIFT) - DIV_W'(1);
        tick  = run && (cnt_q == limit);
        cnt_d = cnt_q;
        if (!run)
            cnt_d = '0;
        else if (cnt_q == limit)
            cnt_d = '0;
        else
            cnt_d = cnt_q + DIV_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assert_div_in_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> cnt_q <= limit);
    assert_div_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> cnt_q == '0);
endmodule

// File: rtl/spi_frame_seq.sv
module spi_frame_seq
    import spi_sck_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  start,
    input  mode_t cfg_live,
    input  logic  tick,
    output mode_t cfg_cur,
    output logic  busy,
    output logic  tog,
    output logic  sample_stb,
    output logic  shift_stb,
    output logic  done
);
    typedef struct packed {
        seq_st_e          st;
        logic [CNT_W-1:0] hcnt;
        logic             tog;
        logic             smp;
        logic             sft;
        logic             done;
        mode_t            cfg;
    } seq_t;

    seq_t q, d;
    logic lead, last;

    always_comb begin
        d      = q;
        d.smp  = 1'b0;
        d.sft  = 1'b0;
        d.done = 1'b0;
        lead   = !q.tog;
        last   = (q.hcnt == CNT_W'(1));
        case (q.st)
            ST_IDLE: begin
                d.tog = 1'b0;
                if (start) begin
                    d.cfg = cfg_live;
                    if (cfg_live.setup != '0) begin
                        d.st   = ST_SETUP;
                        d.hcnt = gap_halves(cfg_live.setup);
                    end else begin
                        d.st   = ST_BITS;
                        d.hcnt = bit_halves(cfg_live.len_m1);
                    end
                end
            end
            ST_SETUP: begin
                if (tick) begin
                    if (last) begin
                        d.st   = ST_BITS;
                        d.hcnt = bit_halves(q.cfg.len_m1);
                    end else begin
                        d.hcnt = q.hcnt - CNT_W'(1);
                    end
                end
            end
            ST_BITS: begin
                if (tick) begin
                    d.tog = !q.tog;
                    d.smp = q.cfg.cpha ? !lead : lead;
                    d.sft = q.cfg.cpha ? lead : (!lead && !last);
                    if (last) begin
                        if (q.cfg.hold != '0) begin
                            d.st   = ST_HOLD;
                            d.hcnt = gap_halves(q.cfg.hold);
                        end else begin
                            d.st   = ST_IDLE;
                            d.done = 1'b1;
                        end
                    end else begin
                        d.hcnt = q.hcnt - CNT_W'(1);
                    end
                end
            end
            default: begin
                if (tick) begin
                    if (last) begin
                        d.st   = ST_IDLE;
                        d.done = 1'b1;
                    end else begin
                        d.hcnt = q.hcnt - CNT_W'(1);
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{st: ST_IDLE, default: '0};
        else        q <= d;
    end

    assign cfg_cur    = q.cfg;
    assign busy       = (q.st != ST_IDLE);
    assign tog        = q.tog;
    assign sample_stb = q.smp;
    assign shift_stb  = q.sft;
    assign done       = q.done;

    assert_cfg_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st != ST_IDLE) |=> (q.st == ST_IDLE || $stable(q.cfg)));
    assert_idle_level_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st != ST_BITS) |-> !q.tog);
    assert_strobe_on_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (q.smp || q.sft) |-> $past(tick));
    assert_done_after_frame_R9: assert property (@(posedge clk) disable iff (!rst_n)
        q.done |-> (q.st == ST_IDLE && $past(q.st) != ST_IDLE));
    assert_start_opens_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_IDLE && start) |=> q.st != ST_IDLE);
endmodule

// File: rtl/spi_sck_framer.sv
module spi_sck_framer
    import spi_sck_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [MODE_W-1:0]    mode_word,
    input  logic                 start,
    output logic                 sck,
    output logic                 cs_level,
    output logic                 frame_active,
    output logic                 sample_stb,
    output logic                 shift_stb,
    output logic                 frame_done,
    output logic                 msb_first,
    output logic [FLD_W-1:0]     char_len_m1,
    output logic                 order_bad
);
    mode_t cfg_live, cfg_cur;
    logic  busy, tog, tick;

    spi_mode_decode u_dec (
        .mode_word (mode_word),
        .cfg       (cfg_live)
    );

    spi_sck_prescaler #(.PM_W(FLD_W)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (busy),
        .pm    (cfg_cur.pm),
        .div16 (cfg_cur.div16),
        .tick  (tick)
    );

    spi_frame_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .cfg_live   (cfg_live),
        .tick       (tick),
        .cfg_cur    (cfg_cur),
        .busy       (busy),
        .tog        (tog),
        .sample_stb (sample_stb),
        .shift_stb  (shift_stb),
        .done       (frame_done)
    );

    always_comb begin
        sck          = busy ? (cfg_cur.cpol ^ tog) : cfg_live.cpol;
        cs_level     = busy ? !cfg_cur.cs_low : cfg_live.cs_low;
        frame_active = busy;
        msb_first    = cfg_cur.msb;
        char_len_m1  = cfg_cur.len_m1;
        order_bad    = busy && cfg_cur.msb &&
                       !(cfg_cur.len_m1 == FLD_W'(7) || cfg_cur.len_m1 == FLD_W'(15));
    end

    assert_done_not_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |-> !frame_active);
endmodule

// File: tb/spi_sck_framer_test.sv
module spi_sck_framer_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] mode_word;
    logic        start;
    logic        sck, cs_level, frame_active, sample_stb, shift_stb, frame_done;
    logic        msb_first, order_bad;
    logic [3:0]  char_len_m1;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    spi_sck_framer uut (
        .clk(clk), .rst_n(rst_n), .mode_word(mode_word), .start(start),
        .sck(sck), .cs_level(cs_level), .frame_active(frame_active),
        .sample_stb(sample_stb), .shift_stb(shift_stb), .frame_done(frame_done),
        .msb_first(msb_first), .char_len_m1(char_len_m1), .order_bad(order_bad)
    );

    task automatic chk_eq(string req, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(bit cpol, bit cpha, bit msb, bit div16, int pm,
                                       bit csl, int len_m1, int s, int a);
        logic [31:0] w;
        w = '0;
        w[31] = cpol; w[30] = cpha; w[29] = msb; w[28] = div16;
        w[27:24] = pm[3:0]; w[20] = csl; w[19:16] = len_m1[3:0];
        w[15:12] = s[3:0]; w[11:8] = a[3:0];
        return w;
    endfunction

    task automatic run_frame(input logic [31:0] m, input bit mid_evt, input logic [31:0] m2);
        int h, n, s, a, t, lim;
        int busy_cnt, toggles, first_tog, last_tog, smp_cnt, sft_cnt;
        int align_err, cs_err, done_cnt, done_idx;
        bit cpol, cpha, prev_sck, lead, exp_smp, exp_sft, exp_bad;
        cpol = m[31]; cpha = m[30];
        h = (m[28] ? 32 : 2) * (int'(m[27:24]) + 1);
        n = int'(m[19:16]) + 1;
        s = int'(m[15:12]);
        a = int'(m[11:8]);
        t = 2 * h * (s + n + a);
        lim = t + 20;
        exp_bad = m[29] && !(n == 8 || n == 16);
        busy_cnt = 0; toggles = 0; first_tog = -1; last_tog = -1;
        smp_cnt = 0; sft_cnt = 0; align_err = 0; cs_err = 0; done_cnt = 0; done_idx = -1;
        prev_sck = cpol;
        @(negedge clk);
        mode_word = m;
        start = 1'b1;
        for (int i = 0; i < lim; i++) begin
            @(negedge clk);
            if (i == 0) start = 1'b0;
            if (mid_evt && i == t / 2) begin mode_word = m2; start = 1'b1; end
            if (mid_evt && i == t / 2 + 1) start = 1'b0;
            if (i == 0) begin
                chk_eq("R10 msb_first", int'(msb_first), int'(m[29]));
                chk_eq("R10 char_len_m1", int'(char_len_m1), n - 1);
                chk_eq("R10 order_bad", int'(order_bad), int'(exp_bad));
            end
            if (frame_active) begin
                busy_cnt++;
                if (cs_level != !m[20]) cs_err++;
            end else if (cs_level != m[20]) cs_err++;
            if (sck != prev_sck) begin
                toggles++;
                if (first_tog < 0) first_tog = i;
                last_tog = i;
                lead = (sck != cpol);
                exp_smp = cpha ? !lead : lead;
                exp_sft = cpha ? lead : (!lead && toggles != 2 * n);
                if (sample_stb != exp_smp || shift_stb != exp_sft) align_err++;
            end else if (sample_stb || shift_stb) align_err++;
            smp_cnt += int'(sample_stb);
            sft_cnt += int'(shift_stb);
            if (frame_done) begin done_cnt++; done_idx = i; end
            prev_sck = sck;
        end
        chk_eq("R9 frame_active length", busy_cnt, t);
        chk_eq("R9 done pulse count", done_cnt, 1);
        chk_eq("R9 done position", done_idx, t);
        chk_eq("R4 edge count", toggles, 2 * n);
        chk_eq("R6 setup gap", first_tog, (2 * s + 1) * h);
        chk_eq("R6 hold gap", t - last_tog, 2 * a * h);
        chk_eq("R2 half period", last_tog - first_tog, (2 * n - 1) * h);
        chk_eq("R5 sample count", smp_cnt, n);
        chk_eq("R5 shift count", sft_cnt, cpha ? n : n - 1);
        chk_eq("R5 strobe alignment errors", align_err, 0);
        chk_eq("R8 chip-select level errors", cs_err, 0);
        chk_eq("R3 sck back at idle", int'(sck), int'(cpol));
    endtask

    initial begin
        rst_n = 1'b0;
        start = 1'b0;
        mode_word = mk(1, 0, 0, 0, 0, 1, 7, 0, 0);
        repeat (3) @(negedge clk);
        chk_eq("R1 sck idle in reset", int'(sck), 1);
        chk_eq("R1 frame_active in reset", int'(frame_active), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk_eq("R1 sck idle", int'(sck), 1);
        chk_eq("R1 cs idle", int'(cs_level), 1);
        chk_eq("R1 frame_active", int'(frame_active), 0);
        chk_eq("R1 strobes", int'(sample_stb) + int'(shift_stb) + int'(frame_done), 0);
        mode_word = mk(0, 0, 0, 0, 0, 0, 7, 0, 0);
        @(negedge clk);
        chk_eq("R3 idle follows live bit", int'(sck), 0);
        chk_eq("R8 idle cs follows live bit", int'(cs_level), 0);

        // Main sweep: prescale, polarity/phase, length, gaps.
        for (int pm = 0; pm < 4; pm++)
            for (int md = 0; md < 4; md++)
                for (int li = 0; li < 2; li++)
                    for (int s = 0; s < 3; s += 2)
                        for (int a = 0; a < 2; a++)
                            run_frame(mk(md[1], md[0], (li == 1) && md[0], 0, pm, pm[0],
                                         li ? 15 : 3, s, a), 0, '0);

        // R10: bit order against lengths
        run_frame(mk(0, 0, 1, 0, 0, 0, 11, 0, 0), 0, '0);
        run_frame(mk(1, 1, 1, 0, 1, 1, 7, 1, 0), 0, '0);
        run_frame(mk(0, 1, 0, 0, 0, 0, 11, 0, 1), 0, '0);
        // R2: divide-by-16 at the fastest and slowest prescale
        run_frame(mk(0, 0, 0, 1, 0, 1, 3, 1, 1), 0, '0);
        run_frame(mk(1, 0, 0, 1, 15, 0, 3, 0, 0), 0, '0);
        // R7: mode change and start request mid-frame
        run_frame(mk(0, 0, 0, 0, 1, 1, 7, 1, 1), 1, mk(0, 1, 1, 1, 9, 1, 3, 5, 4));
        run_frame(mk(1, 1, 0, 0, 0, 0, 15, 0, 0), 1, mk(1, 0, 0, 0, 3, 0, 4, 0, 2));

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #1900000;
        if (!finished) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule